// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block is the counting core of a real-time clock. A sub-second counter driven through a prescaler from a timebase strobe feeds a chain of packed-BCD counters. The chain holds seconds, minutes, hours, day of week, day of month and month, and the year is one 16-bit word whose upper byte is the BCD century and whose lower byte is the BCD year within the century. Month lengths and leap years are applied when the day of month rolls over.

Software reaches every counter and two control words through a simple register port. Reads are combinational from the slot index, and writes take one clock. To set the time, software stops the counter with the prescaler held clear, loads the fields, then starts it. A sticky carry flag is set on every seconds advance. Software clears it before a multi-slot read and checks it afterwards, so it can tell when the read was torn and must be retried. The flag can also raise an interrupt.

Top module: `bcd_rtc_core`

## Requirements
- R1: Registers are addressed by a 4-bit slot index. Slot 0 is the sub-second count, slots 1 to 7 are seconds, minutes, hours, weekday, day, month and year, slot 14 is control word A and slot 15 is control word B. Slots 8 to 13 read as 0 and ignore writes. Fields narrower than 16 bits are written from, and read back on, the low bits.
- R2: After reset the time reads 00:00:00, weekday 0, day 01, month 01, year 16'h2000. Both control words and the interrupt are 0.
- R3: Control word B holds an enable in bit 3, a prescaler clear in bit 1 and a start in bit 0, and all three read back as written. Counting happens only while bit 0 is 1 and bit 1 is 0. While bit 1 is 1, the prescaler and the sub-second count are held at 0. Bit 3 has no effect on counting.
- R4: The sub-second count advances once per PRESCALE timebase strobes while counting. It wraps from FRAC_STEPS-1 to 0, and the seconds advance on the strobe that causes the wrap. Writes to slot 0 are ignored.
- R5: Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours. Hours roll from 23 to 00 and carry into the day. Every BCD digit carries from 9 to 0.
- R6: The weekday advances on each day carry and rolls from 06 to 00.
- R7: The day of month rolls back to 01 after 28 in February of a common year, after 29 in February of a leap year, after 30 in April, June, September and November, and after 31 otherwise. A year is a leap year when the BCD low byte of the year is divisible by 4; 00 counts as a leap year.
- R8: After month 12, the month becomes 01 and the year increments. A low byte of 99 becomes 00 and the century byte increments, with 9999 wrapping to 0000.
- R9: Bit 7 of control word A is the carry flag. It is set on each seconds advance. Writing 0 to it clears it and writing 1 leaves it unchanged. A set and a clear in the same cycle leave it set.
- R10: Bit 4 of control word A is the carry interrupt enable. carry_irq_o is 1 exactly while the flag and the enable are both 1.
- R11: A write to a counter slot while counting shows on the next cycle without disturbing the prescaler or sub-second phase. If a write and an advance of the same field fall in one cycle, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one cycle per pulse |
| reg_addr_i | input | 4 | Register slot index |
| reg_wr_i | input | 1 | Write strobe for the addressed slot |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the addressed slot |
| carry_irq_o | output | 1 | Carry interrupt |

## Verification
Each calendar vector preloads a full date and time, runs exactly one second of strobes and compares every field. The vectors are chosen so that each one triggers a different rollover:
- a plain seconds step, and a minute carry;
- decimal digit carries in hours and months;
- February end in a common year, a leap year and the century year 2100;
- a 30-day month and a 31-day month;
- year, century and full-word wraps.

Directed sequences count strobes one at a time, which separates the prescale ratio from the sub-second wrap. They also place a register write, or a flag clear, on exactly the strobe that advances the seconds, to test which action has priority.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [2:0] FLD_SEC  = 3'd1;
  localparam logic [2:0] FLD_MIN  = 3'd2;
  localparam logic [2:0] FLD_HR   = 3'd3;
  localparam logic [2:0] FLD_WDAY = 3'd4;
  localparam logic [2:0] FLD_DAY  = 3'd5;
  localparam logic [2:0] FLD_MON  = 3'd6;
  localparam logic [2:0] FLD_YEAR = 3'd7;

  // two-digit BCD increment, 99 wraps to 00
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return (v[7:4] == 4'd9) ? 8'h00 : {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD value divisible by 4: even tens -> units 0/4/8, odd tens -> units 2/6
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE   = 4,
  parameter int FRAC_STEPS = 64,
  localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1,
  localparam int FRAC_W = $clog2(FRAC_STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic              tick_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic              sec_step_o
);
  logic [PRE_W-1:0]  pre_q;
  logic [FRAC_W-1:0] frac_q;
  logic adv, pre_last, frac_last;

  assign adv       = run_i && tick_i && !clr_i;
  assign pre_last  = pre_q == PRE_W'(PRESCALE - 1);
  assign frac_last = frac_q == FRAC_W'(FRAC_STEPS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      frac_q <= '0;
    end else if (clr_i) begin
      pre_q  <= '0;
      frac_q <= '0;
    end else if (adv) begin
      if (pre_last) begin
        pre_q  <= '0;
        frac_q <= frac_last ? '0 : frac_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign frac_o     = frac_q;
  assign sec_step_o = adv && pre_last && frac_last;

  a_r3_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(frac_o));
  a_r3_clear_holds_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (frac_o == '0));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        step_i,
  input  logic        wr_i,
  input  logic [2:0]  wr_field_i,
  input  logic [15:0] wdata_i,
  output logic [7:0]  sec_o,
  output logic [7:0]  min_o,
  output logic [7:0]  hr_o,
  output logic [7:0]  wday_o,
  output logic [7:0]  day_o,
  output logic [7:0]  mon_o,
  output logic [15:0] year_o
);
  logic [7:0]  sec_q, min_q, hr_q, wday_q, day_q, mon_q;
  logic [15:0] year_q;
  logic c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0] day_last;

  assign day_last = month_last(mon_q, bcd_leap(year_q[7:0]));
  assign c_min = step_i && (sec_q == 8'h59);
  assign c_hr  = c_min && (min_q == 8'h59);
  assign c_day = c_hr && (hr_q == 8'h23);
  assign c_mon = c_day && (day_q == day_last);
  assign c_yr  = c_mon && (mon_q == 8'h12);

  function automatic logic hit(input logic [2:0] f);
    return wr_i && (wr_field_i == f);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hr_q   <= 8'h00;
      wday_q <= 8'h00;
      day_q  <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 16'h2000;
    end else begin
      if (hit(FLD_SEC))       sec_q <= wdata_i[7:0];
      else if (step_i)        sec_q <= (sec_q == 8'h59) ? 8'h00 : bcd_inc(sec_q);
      if (hit(FLD_MIN))       min_q <= wdata_i[7:0];
      else if (c_min)         min_q <= (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
      if (hit(FLD_HR))        hr_q <= wdata_i[7:0];
      else if (c_hr)          hr_q <= (hr_q == 8'h23) ? 8'h00 : bcd_inc(hr_q);
      if (hit(FLD_WDAY))      wday_q <= wdata_i[7:0];
      else if (c_day)         wday_q <= (wday_q == 8'h06) ? 8'h00 : bcd_inc(wday_q);
      if (hit(FLD_DAY))       day_q <= wdata_i[7:0];
      else if (c_day)         day_q <= (day_q == day_last) ? 8'h01 : bcd_inc(day_q);
      if (hit(FLD_MON))       mon_q <= wdata_i[7:0];
      else if (c_mon)         mon_q <= (mon_q == 8'h12) ? 8'h01 : bcd_inc(mon_q);
      if (hit(FLD_YEAR))      year_q <= wdata_i;
      else if (c_yr) begin
        if (year_q[7:0] == 8'h99) year_q <= {bcd_inc(year_q[15:8]), 8'h00};
        else                      year_q <= {year_q[15:8], bcd_inc(year_q[7:0])};
      end
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hr_o   = hr_q;
  assign wday_o = wday_q;
  assign day_o  = day_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;

  a_r5_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_i && sec_q == 8'h59) |=> (sec_q == 8'h00));
  a_r6_wday_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_i && sec_q == 8'h59 && min_q == 8'h59 && hr_q == 8'h23 && wday_q == 8'h06)
    |=> (wday_q == 8'h00));
  a_r8_new_year: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_i && sec_q == 8'h59 && min_q == 8'h59 && hr_q == 8'h23 &&
     day_q == 8'h31 && mon_q == 8'h12) |=> (mon_q == 8'h01 && day_q == 8'h01));
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_a_i,
  input  logic       wr_b_i,
  input  logic [7:0] wdata_i,
  input  logic       set_cf_i,
  output logic [7:0] ctl_a_o,
  output logic [7:0] ctl_b_o,
  output logic       run_o,
  output logic       clr_o,
  output logic       irq_o
);
  logic cf_q, cie_q, en_q, clr_q, start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cf_q    <= 1'b0;
      cie_q   <= 1'b0;
      en_q    <= 1'b0;
      clr_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (set_cf_i)                   cf_q <= 1'b1;
      else if (wr_a_i && !wdata_i[7]) cf_q <= 1'b0;
      if (wr_a_i) cie_q <= wdata_i[4];
      if (wr_b_i) begin
        en_q    <= wdata_i[3];
        clr_q   <= wdata_i[1];
        start_q <= wdata_i[0];
      end
    end
  end

  assign ctl_a_o = {cf_q, 2'b00, cie_q, 4'b0000};
  assign ctl_b_o = {4'b0000, en_q, 1'b0, clr_q, start_q};
  assign run_o   = start_q && !clr_q;
  assign clr_o   = clr_q;
  assign irq_o   = cf_q && cie_q;

  a_r9_set_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_cf_i |=> cf_q);
  a_r9_write_one_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a_i && wdata_i[7] && !set_cf_i) |=> (cf_q == $past(cf_q)));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE   = 4,
  parameter int FRAC_STEPS = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic [3:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        carry_irq_o
);
  localparam int FRAC_W = $clog2(FRAC_STEPS);
  localparam logic [3:0] SLOT_CTL_A = 4'd14;
  localparam logic [3:0] SLOT_CTL_B = 4'd15;

  logic [FRAC_W-1:0] frac;
  logic sec_step, run, clr;
  logic [7:0] sec, min, hr, wday, day, mon, ctl_a, ctl_b;
  logic [15:0] year;
  logic cal_wr;

  assign cal_wr = reg_wr_i && !reg_addr_i[3] && (reg_addr_i[2:0] != 3'd0);

  rtc_prescaler #(.PRESCALE(PRESCALE), .FRAC_STEPS(FRAC_STEPS)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .clr_i(clr), .tick_i,
    .frac_o(frac), .sec_step_o(sec_step)
  );

  rtc_calendar u_cal (
    .clk_i, .rst_ni, .step_i(sec_step), .wr_i(cal_wr),
    .wr_field_i(reg_addr_i[2:0]), .wdata_i(reg_wdata_i),
    .sec_o(sec), .min_o(min), .hr_o(hr), .wday_o(wday),
    .day_o(day), .mon_o(mon), .year_o(year)
  );

  rtc_ctrl u_ctl (
    .clk_i, .rst_ni,
    .wr_a_i(reg_wr_i && reg_addr_i == SLOT_CTL_A),
    .wr_b_i(reg_wr_i && reg_addr_i == SLOT_CTL_B),
    .wdata_i(reg_wdata_i[7:0]), .set_cf_i(sec_step),
    .ctl_a_o(ctl_a), .ctl_b_o(ctl_b), .run_o(run), .clr_o(clr), .irq_o(carry_irq_o)
  );

  always_comb begin
    case (reg_addr_i)
      4'd0:       reg_rdata_o = {{(16-FRAC_W){1'b0}}, frac};
      4'd1:       reg_rdata_o = {8'h00, sec};
      4'd2:       reg_rdata_o = {8'h00, min};
      4'd3:       reg_rdata_o = {8'h00, hr};
      4'd4:       reg_rdata_o = {8'h00, wday};
      4'd5:       reg_rdata_o = {8'h00, day};
      4'd6:       reg_rdata_o = {8'h00, mon};
      4'd7:       reg_rdata_o = year;
      SLOT_CTL_A: reg_rdata_o = {8'h00, ctl_a};
      SLOT_CTL_B: reg_rdata_o = {8'h00, ctl_b};
      default:    reg_rdata_o = 16'h0000;
    endcase
  end

  a_r10_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == SLOT_CTL_A && !reg_wdata_i[7] && !sec_step) |=> !carry_irq_o);
endmodule

// File: tb/tb_bcd_rtc_core.sv
`timescale 1ns/1ps
module tb_bcd_rtc_core;
  localparam int PRESCALE   = 2;
  localparam int FRAC_STEPS = 4;
  localparam int SEC_TICKS  = PRESCALE * FRAC_STEPS;
  localparam int NV = 13;
  // {pre-state, post-state}: each state is {sec,min,hr,wday,day,mon,year}
  localparam logic [127:0] VEC [NV] = '{
    {64'h10_00_00_02_15_03_2024, 64'h11_00_00_02_15_03_2024},
    {64'h59_10_05_01_07_06_2024, 64'h00_11_05_01_07_06_2024},
    {64'h59_59_23_06_31_01_2024, 64'h00_00_00_00_01_02_2024},
    {64'h59_59_23_03_28_02_2023, 64'h00_00_00_04_01_03_2023},
    {64'h59_59_23_03_28_02_2024, 64'h00_00_00_04_29_02_2024},
    {64'h59_59_23_04_29_02_2024, 64'h00_00_00_05_01_03_2024},
    {64'h59_59_23_01_30_04_2024, 64'h00_00_00_02_01_05_2024},
    {64'h59_59_23_01_30_05_2024, 64'h00_00_00_02_31_05_2024},
    {64'h59_59_23_05_31_12_2099, 64'h00_00_00_06_01_01_2100},
    {64'h59_59_23_02_31_12_9999, 64'h00_00_00_03_01_01_0000},
    {64'h59_59_09_02_14_07_2024, 64'h00_00_10_02_14_07_2024},
    {64'h59_59_23_05_28_02_2100, 64'h00_00_00_06_29_02_2100},
    {64'h59_59_23_02_30_09_2024, 64'h00_00_00_03_01_10_2024}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [3:0] addr = '0;
  logic wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bcd_rtc_core #(.PRESCALE(PRESCALE), .FRAC_STEPS(FRAC_STEPS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_addr_i(addr),
    .reg_wr_i(wr_en), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .carry_irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // strobe that lands on the seconds advance, together with a write
  task automatic tick_with_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    tick = 1'b1; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [15:0] v;
    rd(4'd1, v); t[63:56] = v[7:0];
    rd(4'd2, v); t[55:48] = v[7:0];
    rd(4'd3, v); t[47:40] = v[7:0];
    rd(4'd4, v); t[39:32] = v[7:0];
    rd(4'd5, v); t[31:24] = v[7:0];
    rd(4'd6, v); t[23:16] = v[7:0];
    rd(4'd7, v); t[15:0]  = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad + 1);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [63:0] t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    read_time(t);  chk("R2 time", t, 64'h00_00_00_00_01_01_2000);
    rd(4'd0, v);   chk("R2 subsec", 64'(v), 64'h0);
    rd(4'd14, v);  chk("R2 ctl A", 64'(v), 64'h0);
    rd(4'd15, v);  chk("R2 ctl B", 64'(v), 64'h0);
    chk("R2 irq", 64'(irq), 64'h0);

    // R1 unused slots, R4 slot 0 read-only
    wr(4'd9, 16'h1234); rd(4'd9, v); chk("R1 unused slot", 64'(v), 64'h0);
    wr(4'd0, 16'h0003); rd(4'd0, v); chk("R4 subsec write ignored", 64'(v), 64'h0);
    wr(4'd1, 16'h0037); rd(4'd1, v); chk("R1 sec slot", 64'(v), 64'h37);
    wr(4'd1, 16'h0000);

    // R3 stopped, clear held, readback
    ticks(20);
    rd(4'd0, v); chk("R3 not started subsec", 64'(v), 64'h0);
    rd(4'd1, v); chk("R3 not started sec", 64'(v), 64'h0);
    wr(4'd15, 16'h000B); rd(4'd15, v); chk("R3 ctl B readback", 64'(v), 64'h000B);
    ticks(20);
    rd(4'd0, v); chk("R3 clear holds subsec", 64'(v), 64'h0);

    // R4 prescale ratio, start without enable (R3)
    wr(4'd15, 16'h0001);
    ticks(2); rd(4'd0, v); chk("R4 R3 first step", 64'(v), 64'h1);
    ticks(1); rd(4'd0, v); chk("R4 mid prescale", 64'(v), 64'h1);
    ticks(1); rd(4'd0, v); chk("R4 second step", 64'(v), 64'h2);
    ticks(4);
    rd(4'd0, v); chk("R4 subsec wrap", 64'(v), 64'h0);
    rd(4'd1, v); chk("R4 sec advance", 64'(v), 64'h1);

    // R9 flag behaviour
    rd(4'd14, v); chk("R9 flag set", 64'(v), 64'h0080);
    wr(4'd14, 16'h0080); rd(4'd14, v); chk("R9 write one keeps", 64'(v), 64'h0080);
    wr(4'd14, 16'h0000); rd(4'd14, v); chk("R9 write zero clears", 64'(v), 64'h0);
    ticks(SEC_TICKS - 1);
    tick_with_wr(4'd14, 16'h0000);
    rd(4'd14, v); chk("R9 set wins over clear", 64'(v), 64'h0080);
    rd(4'd1, v);  chk("R9 sec advanced", 64'(v), 64'h2);

    // R10 interrupt
    chk("R10 irq off without enable", 64'(irq), 64'h0);
    wr(4'd14, 16'h0090); #0.5; chk("R10 irq on", 64'(irq), 64'h1);
    wr(4'd14, 16'h0010); #0.5; chk("R10 irq off after clear", 64'(irq), 64'h0);
    ticks(SEC_TICKS);    #0.5; chk("R10 irq on carry", 64'(irq), 64'h1);
    wr(4'd14, 16'h0080); #0.5; chk("R10 irq off when disabled", 64'(irq), 64'h0);
    wr(4'd14, 16'h0000);

    // R11 write while running
    ticks(3);
    wr(4'd1, 16'h0042);
    rd(4'd1, v); chk("R11 write lands", 64'(v), 64'h42);
    rd(4'd0, v); chk("R11 subsec undisturbed", 64'(v), 64'h1);
    ticks(SEC_TICKS - 4);
    rd(4'd1, v); chk("R11 no early step", 64'(v), 64'h42);
    ticks(1);
    rd(4'd1, v); chk("R11 step on schedule", 64'(v), 64'h43);
    ticks(SEC_TICKS - 1);
    tick_with_wr(4'd1, 16'h0020);
    rd(4'd1, v); chk("R11 write wins", 64'(v), 64'h20);
    rd(4'd2, v); chk("R11 min untouched", 64'(v), 64'h0);

    // R5 R6 R7 R8 calendar vectors
    for (int i = 0; i < NV; i++) begin
      logic [63:0] pre_t, exp_t, act_t;
      string tag;
      pre_t = VEC[i][127:64];
      exp_t = VEC[i][63:0];
      wr(4'd15, 16'h0002);
      wr(4'd1, {8'h00, pre_t[63:56]});
      wr(4'd2, {8'h00, pre_t[55:48]});
      wr(4'd3, {8'h00, pre_t[47:40]});
      wr(4'd4, {8'h00, pre_t[39:32]});
      wr(4'd5, {8'h00, pre_t[31:24]});
      wr(4'd6, {8'h00, pre_t[23:16]});
      wr(4'd7, pre_t[15:0]);
      wr(4'd15, 16'h0009);
      ticks(SEC_TICKS);
      wr(4'd15, 16'h0000);
      read_time(act_t);
      tag = $sformatf("R5 R6 R7 R8 vector %0d", i);
      chk(tag, act_t, exp_t);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule